// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Shadowed Settings

This block produces one pulse-width-modulated output per channel. Each channel's frequency comes from an N-bit phase accumulator. A programmed increment is added to the accumulator on every clock. The duty cycle comes from comparing the accumulator's top eight bits against an 8-bit on-time threshold. A larger threshold gives a shorter high time. The output frequency is the input clock times the increment, divided by 2^N. For example, with a 25 MHz input clock, N = 16 and an increment of 1024, the period is 64 clocks and the output runs at 390.625 kHz.

Software writes one 32-bit control word per channel through a simple memory-mapped read/write port. Channels sit in 0x400-byte windows. New increment and threshold values land in a shadow copy. They only reach the running (active) copy when software sets the update-request bit. A channel refuses to start until at least one update has been taken since reset. The required order is therefore: update first, then enable. Clearing the enable bit stops the output at once and rewinds the accumulator. The shadow settings are kept.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset every control word reads 0 and every PWM output is low.
- R2: Control word layout: bit 31 is enable, bit 30 is update request, bits 8+N-1..8 are the increment (N = INC_W, 16 by default), and bits 7..0 are the on-time threshold. Reads return the shadow fields, and bits 29..8+N read 0.
- R3: Channel c is decoded only at byte address c*0x400. A write to any other offset inside a window is ignored, and a read from it returns 0.
- R4: A write with bit 30 set makes bit 30 read back 1 in the following cycle. On the next clock edge the shadow fields are copied into the active copy, and bit 30 then reads 0.
- R5: Changing the increment or threshold without bit 30 set leaves the output waveform unchanged, even while the channel runs.
- R6: A write of enable = 1 before any update has been taken since reset is ignored: bit 31 reads 0 and the output stays low.
- R7: While running, the output period is 2^N / increment clocks. So for increment m*2^(N-8), a 1024-clock window holds exactly 4*m rising edges when the threshold is non-zero.
- R8: The output is high while the accumulator's top 8 bits are >= the active threshold. For increment m*2^(N-8) and a threshold that is a multiple of m, a 1024-clock window holds 4*(256 - threshold) high cycles.
- R9: Writing enable = 0 drives the output low from the write's clock edge and zeroes the accumulator, while the shadow fields still read back. After a re-enable the output first rises after threshold/m clocks.
- R10: Channels are independent. Writing or running one channel does not change another channel's readback or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 10+CH_W | Byte address (CH_W = clog2 of channel count, min 1) |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NCH | PWM output per channel |

## Verification
A write takes effect at the clock edge on which the strobe is sampled. Shadow fields and bit 30 are therefore visible to a read half a cycle later. The active copy changes one edge after that, and an enable or disable acts on the output from the write edge itself. The bench drives on falling edges and samples just after them. It checks the update bit in the first and second sample after the write. It waits two cycles after every update before measuring. It counts the first-rise delay from the falling edge that follows the enable. Waveform checks count high cycles and rising edges over 1024-clock windows. Every chosen period divides that window, so each count has one exact expected value whatever the starting phase.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  // Control word field positions (software-visible, decoded by each channel)
  localparam int EN_BIT   = 31;
  localparam int UPD_BIT  = 30;
  localparam int INC_LSB  = 8;
  localparam int THR_W    = 8;
  // Per-channel register window is 2**WIN_LSB bytes (0x400)
  localparam int WIN_LSB  = 10;
  localparam int WORD_W   = 32;

  typedef logic [THR_W-1:0] thr_t;
endpackage

// File: rtl/pwm_reg_decode.sv
module pwm_reg_decode
  import pwm_phase_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2,
  parameter int AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] ch_word [NCH],
  output logic [NCH-1:0]    ch_wr,
  output logic [WORD_W-1:0] bus_rdata
);
  logic [CH_W-1:0] ch_idx;
  logic            hit;

  assign ch_idx = bus_addr[AW-1 -: CH_W];
  assign hit    = (bus_addr[WIN_LSB-1:0] == '0) && (32'(ch_idx) < NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_wr[i] = bus_wr && hit && (ch_idx == CH_W'(i));
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit && (ch_idx == CH_W'(i))) bus_rdata = ch_word[i];
    end
  end

  // R3
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr));
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
  import pwm_phase_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [INC_W-1:0] inc,
  input  thr_t             thr,
  output logic             pwm_o
);
  logic [INC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = '0;
    if (run) acc_d = acc_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign pwm_o = run && (acc_q[INC_W-1 -: THR_W] >= thr);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_phase_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word,
  output logic              pwm_o
);
  logic             en_q, en_d, upd_q, upd_d, seen_q, seen_d;
  logic [INC_W-1:0] inc_sh_q, inc_sh_d, inc_act_q, inc_act_d;
  thr_t             thr_sh_q, thr_sh_d, thr_act_q, thr_act_d;

  always_comb begin
    en_d      = en_q;
    upd_d     = 1'b0;
    seen_d    = seen_q;
    inc_sh_d  = inc_sh_q;
    thr_sh_d  = thr_sh_q;
    inc_act_d = inc_act_q;
    thr_act_d = thr_act_q;
    if (upd_q) begin
      inc_act_d = inc_sh_q;
      thr_act_d = thr_sh_q;
      seen_d    = 1'b1;
    end
    if (wr) begin
      en_d     = wdata[EN_BIT] & seen_q;
      upd_d    = wdata[UPD_BIT];
      inc_sh_d = wdata[INC_LSB +: INC_W];
      thr_sh_d = wdata[THR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      upd_q     <= 1'b0;
      seen_q    <= 1'b0;
      inc_sh_q  <= '0;
      thr_sh_q  <= '0;
      inc_act_q <= '0;
      thr_act_q <= '0;
    end else begin
      en_q      <= en_d;
      upd_q     <= upd_d;
      seen_q    <= seen_d;
      inc_sh_q  <= inc_sh_d;
      thr_sh_q  <= thr_sh_d;
      inc_act_q <= inc_act_d;
      thr_act_q <= thr_act_d;
    end
  end

  always_comb begin
    rd_word                       = '0;
    rd_word[EN_BIT]               = en_q;
    rd_word[UPD_BIT]              = upd_q;
    rd_word[INC_LSB +: INC_W]     = inc_sh_q;
    rd_word[THR_W-1:0]            = thr_sh_q;
  end

  pwm_phase_core #(.INC_W(INC_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .inc   (inc_act_q),
    .thr   (thr_act_q),
    .pwm_o (pwm_o)
  );

  // R6
  en_needs_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> seen_q);
  // R4
  upd_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !wr) |=> !upd_q);
  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> ($stable(inc_act_q) && $stable(thr_act_q)));
  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_o);
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int  NCH   = 4,
  parameter int  INC_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW    = WIN_LSB + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NCH-1:0]    ch_wr;
  logic [WORD_W-1:0] ch_word [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_reg_decode #(.NCH(NCH), .CH_W(CH_W), .AW(AW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .ch_word   (ch_word),
    .ch_wr     (ch_wr),
    .bus_rdata (bus_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.INC_W(INC_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr      (ch_wr[c]),
      .wdata   (bus_wdata),
      .rd_word (ch_word[c]),
      .pwm_o   (pwm_o[c])
    );
  end
endmodule

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb;
  localparam int NCH = 4;
  localparam int INC_W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_phase_gen #(.NCH(NCH), .INC_W(INC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  function automatic logic [31:0] cw(bit en, bit upd, int inc, int thr);
    return {en, upd, 6'b0, 16'(inc), 8'(thr)};
  endfunction

  task automatic check(string req, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic reg_wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(int a, output logic [31:0] d);
    bus_addr = 12'(a);
    #1 d = bus_rdata;
  endtask

  // counts high cycles and rising edges of one channel over 1024 clocks
  task automatic measure(int ch, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk); prev = pwm_o[ch];
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) hi++;
      if (pwm_o[ch] && !prev) rises++;
      prev = pwm_o[ch];
    end
  endtask

  task automatic low_for(int ch, int cycles, string req);
    int seen_hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) seen_hi++;
    end
    check(req, seen_hi, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, rises, n;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      rd_now(c * 32'h400, d);
      check("R1 reset readback", d, 0);
    end
    check("R1 reset outputs", pwm_o, 0);

    // R6: enable before any update is ignored (channel 1)
    reg_wr(32'h400, cw(1, 0, 256, 0));
    rd_now(32'h400, d);
    check("R6 enable bit ignored", d[31], 0);
    low_for(1, 300, "R6 output stays low");

    // R2: field layout and unused bits
    reg_wr(0, 32'h00AB_CD5A);
    rd_now(0, d);
    check("R2 fields readback", d, 32'h00AB_CD5A);
    reg_wr(0, 32'h0F00_0000);
    rd_now(0, d);
    check("R2 unused bits read zero", d, 0);

    // R4: update bit visible for one cycle
    reg_wr(0, cw(0, 1, 256, 128));
    rd_now(0, d);
    check("R4 update bit set", d[30], 1);
    @(negedge clk);
    rd_now(0, d);
    check("R4 update bit cleared", d[30], 0);

    // R9/R8: enable from zeroed accumulator, first rise after 128 clocks
    reg_wr(0, cw(1, 0, 256, 128));
    n = 0;
    while (!pwm_o[0] && n < 1000) begin @(negedge clk); n++; end
    check("R9 first rise delay", n, 128);
    measure(0, hi, rises);
    check("R8 high count thr=128", hi, 512);
    check("R7 rises inc=256", rises, 4);

    // R5: shadow change without update keeps the waveform
    reg_wr(0, cw(1, 0, 1024, 0));
    rd_now(0, d);
    check("R5 shadow readback", d, cw(1, 0, 1024, 0));
    measure(0, hi, rises);
    check("R5 high count unchanged", hi, 512);
    check("R5 rises unchanged", rises, 4);
    reg_wr(0, cw(1, 1, 256, 0));
    repeat (2) @(negedge clk);
    measure(0, hi, rises);
    check("R5 update applies thr=0", hi, 1024);

    // R7/R8 sweep: inc = m*256 (25 MHz clock: m=4 gives 390.625 kHz)
    for (int m = 1; m <= 8; m = m * 2) begin
      int thrs[4];
      thrs[0] = 0; thrs[1] = m; thrs[2] = 16 * m; thrs[3] = (255 / m) * m;
      for (int j = 0; j < 4; j++) begin
        reg_wr(0, cw(1, 1, 256 * m, thrs[j]));
        repeat (2) @(negedge clk);
        measure(0, hi, rises);
        check("R8 sweep high count", hi, 4 * (256 - thrs[j]));
        check("R7 sweep rising edges", rises, (thrs[j] == 0) ? 0 : 4 * m);
      end
    end

    // R9: disable forces low at once, shadow kept, restart from zero phase
    reg_wr(0, cw(1, 1, 256, 0));
    repeat (2) @(negedge clk);
    check("R9 high before disable", pwm_o[0], 1);
    reg_wr(0, cw(0, 1, 256, 128));
    check("R9 low at disable edge", pwm_o[0], 0);
    rd_now(0, d);
    check("R9 shadow kept", d[29:0], cw(0, 1, 256, 128) & 32'h3FFF_FFFF);
    low_for(0, 300, "R9 stays low while disabled");
    reg_wr(0, cw(1, 0, 256, 128));
    n = 0;
    while (!pwm_o[0] && n < 1000) begin @(negedge clk); n++; end
    check("R9 restart first rise", n, 128);

    // R3: window decoding
    reg_wr(32'h800, cw(0, 0, 16'h1234, 0));
    rd_now(32'h800, d);
    check("R3 channel 2 readback", d, 32'h0012_3400);
    reg_wr(32'h804, 32'h0000_00FF);
    rd_now(32'h804, d);
    check("R3 off-window read zero", d, 0);
    rd_now(32'h800, d);
    check("R3 off-window write ignored", d, 32'h0012_3400);

    // R10: channel independence
    reg_wr(32'hC00, cw(0, 1, 4096, 64));
    reg_wr(32'hC00, cw(1, 0, 4096, 64));
    repeat (2) @(negedge clk);
    measure(3, hi, rises);
    check("R10 channel 3 high count", hi, 768);
    check("R10 channel 3 rises", rises, 64);
    rd_now(0, d);
    check("R10 channel 0 untouched", d, cw(1, 0, 256, 128));
    rd_now(32'h400, d);
    check("R10 channel 1 untouched", d, cw(0, 0, 256, 0));
    check("R10 channel 1/2 outputs low", pwm_o[2:1], 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule